// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. It sits beside the memory access controller. Out of reset it first holds off for a power-up pause. It then runs a counted burst of wake-up refresh cycles. After that it settles into a steady cadence of one CAS-before-RAS refresh per interval. The interval is sized so that every row is refreshed within the retention period. When the last wake-up cycle completes, an init-done flag is raised.

Each refresh cycle is arbitrated with the access controller through a request/grant pair. While its own cycle runs, the sequencer drives the CAS and RAS strobes and flags that it owns them. Refreshes that cannot be granted at once are remembered as a small owed count. If that count would overflow, the retention deadline is taken as missed. A sticky flag is then set and the whole wake-up burst is run again.

All timing is counted in clock cycles and set through parameters. The defaults suit a 125 MHz clock.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and after it is released, `ras_n` and `cas_n` are high and `ref_req`, `ref_active`, `init_done` and `deadline_miss` are low until the pause ends.
- R2: `ref_req` stays low for the first PAUSE_CYC-1 rising clock edges after reset release. It is high after edge PAUSE_CYC.
- R3: Exactly WAKE_COUNT refresh cycles are run after the pause. `init_done` rises as the last of them completes.
- R4: A refresh cycle begins only after a clock edge at which `ref_req` and `ref_gnt` are both high. With the grant held low, the strobes stay high, `ref_active` stays low and `ref_req` stays high.
- R5: Each refresh cycle has four parts. First, CAS is low with RAS high for CSR_CYC cycles. Then RAS is low for RAS_CYC cycles, with CAS still low for the first CHR_CYC of them and high for the rest. Then both strobes are high for PRE_CYC cycles. Finally the block returns idle. `ref_active` is high for the whole cycle, and RAS never falls unless CAS was already low.
- R6: After `init_done` rises, one refresh becomes owed every INTERVAL_CYC cycles. `ref_req` is high on the cycle after the INTERVAL_CYC-th edge.
- R7: Owed refreshes accumulate while no grant arrives, up to BACKLOG_MAX. Each granted cycle pays off one. `ref_req` falls once none is owed.
- R8: An interval that ends with BACKLOG_MAX refreshes already owed sets the sticky `deadline_miss`. It also drops `init_done`, discards the owed count and reruns the full WAKE_COUNT burst, after which `init_done` rises again.
- R9: `ref_req` is never high while `ref_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Grant from the access controller |
| ref_req | output | 1 | Request for a refresh cycle |
| ref_active | output | 1 | Sequencer owns the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| init_done | output | 1 | Power-up sequence complete |
| deadline_miss | output | 1 | Sticky: refresh deadline was exceeded |

## Verification
The bench checks the pause length to the exact edge. A counter that is off by one would request one cycle early or late. It walks one refresh cycle phase by phase against a stored pattern. This catches a swapped CAS/RAS order or a wrong hold length. It counts RAS falls across each wake-up burst, so a burst that is too short or too long is seen. It then withholds the grant to build a backlog. A design that drops owed refreshes pays back too few. A design that saturates without flagging never reruns the wake-up burst.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } seq_phase_e;

  typedef enum logic [1:0] {
    EN_IDLE = 2'd0,
    EN_LEAD = 2'd1,
    EN_ACT  = 2'd2,
    EN_PRE  = 2'd3
  } eng_state_e;
endpackage

// File: rtl/dref_interval_timer.sv
module dref_interval_timer #(
  parameter int PERIOD_CYC = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/dref_backlog.sv
module dref_backlog #(
  parameter int BACKLOG_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic owed_nz,
  output logic overflow
);
  localparam int BW = $clog2(BACKLOG_MAX + 1);
  localparam logic [BW-1:0] FULL = BW'(BACKLOG_MAX);

  logic [BW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (cnt_q != FULL) cnt_d = cnt_q + BW'(1);
        2'b01:   if (cnt_q != '0)   cnt_d = cnt_q - BW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign owed_nz  = (cnt_q != '0);
  assign overflow = inc && !dec && (cnt_q == FULL);
endmodule

// File: rtl/dref_strobe_engine.sv
module dref_strobe_engine
  import dref_pkg::*;
#(
  parameter int CSR_CYC = 1,
  parameter int RAS_CYC = 8,
  parameter int CHR_CYC = 2,
  parameter int PRE_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int MAX_A = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int MAX_C = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  eng_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ras_q, cas_q, ras_d, cas_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      EN_IDLE: if (start) begin
        st_d  = EN_LEAD;
        cnt_d = '0;
      end
      EN_LEAD: if (cnt_q == CW'(CSR_CYC - 1)) begin
        st_d  = EN_ACT;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
      EN_ACT: if (cnt_q == CW'(RAS_CYC - 1)) begin
        st_d  = EN_PRE;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
      EN_PRE: if (cnt_q == CW'(PRE_CYC - 1)) begin
        st_d  = EN_IDLE;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
      default: begin
        st_d  = EN_IDLE;
        cnt_d = '0;
      end
    endcase
    ras_d = (st_d != EN_ACT);
    cas_d = !((st_d == EN_LEAD) || ((st_d == EN_ACT) && (cnt_d < CW'(CHR_CYC))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= EN_IDLE;
      cnt_q <= '0;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ras_q <= ras_d;
      cas_q <= cas_d;
    end
  end

  assign busy  = (st_q != EN_IDLE);
  assign done  = (st_q == EN_PRE) && (cnt_q == CW'(PRE_CYC - 1));
  assign ras_n = ras_q;
  assign cas_n = cas_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dref_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int WAKE_COUNT   = 8,
  parameter int INTERVAL_CYC = 1950,
  parameter int BACKLOG_MAX  = 4,
  parameter int CSR_CYC      = 1,
  parameter int RAS_CYC      = 8,
  parameter int CHR_CYC      = 2,
  parameter int PRE_CYC      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_active,
  output logic ras_n,
  output logic cas_n,
  output logic init_done,
  output logic deadline_miss
);
  localparam int WW = $clog2(WAKE_COUNT + 1);

  seq_phase_e    phase_q, phase_d;
  logic [WW-1:0] wake_q, wake_d;
  logic          miss_q, miss_d;

  logic pause_tick, iv_tick, owed_nz, overflow;
  logic eng_busy, eng_done, start;

  dref_interval_timer #(.PERIOD_CYC(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .run(phase_q == PH_PAUSE), .tick(pause_tick)
  );

  dref_interval_timer #(.PERIOD_CYC(INTERVAL_CYC)) u_interval (
    .clk(clk), .rst_n(rst_n), .run(phase_q == PH_RUN), .tick(iv_tick)
  );

  dref_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_n),
    .clr((phase_q != PH_RUN) || overflow),
    .inc(iv_tick),
    .dec(start && (phase_q == PH_RUN)),
    .owed_nz(owed_nz), .overflow(overflow)
  );

  dref_strobe_engine #(
    .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .CHR_CYC(CHR_CYC), .PRE_CYC(PRE_CYC)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(eng_busy), .done(eng_done), .ras_n(ras_n), .cas_n(cas_n)
  );

  assign ref_req = !eng_busy &&
                   (((phase_q == PH_WAKE) && (wake_q != '0)) ||
                    ((phase_q == PH_RUN) && owed_nz));
  assign start   = ref_req && ref_gnt;

  always_comb begin
    phase_d = phase_q;
    wake_d  = wake_q;
    miss_d  = miss_q;
    case (phase_q)
      PH_PAUSE: if (pause_tick) begin
        phase_d = PH_WAKE;
        wake_d  = WW'(WAKE_COUNT);
      end
      PH_WAKE: begin
        if (start) wake_d = wake_q - WW'(1);
        if ((wake_q == '0) && eng_done) phase_d = PH_RUN;
      end
      PH_RUN: if (overflow) begin
        phase_d = PH_WAKE;
        wake_d  = WW'(WAKE_COUNT);
        miss_d  = 1'b1;
      end
      default: phase_d = PH_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PAUSE;
      wake_q  <= '0;
      miss_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wake_q  <= wake_d;
      miss_q  <= miss_d;
    end
  end

  assign ref_active    = eng_busy;
  assign init_done     = (phase_q == PH_RUN);
  assign deadline_miss = miss_q;
endmodule

// File: rtl/dref_seq_checker.sv
module dref_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt,
  input logic ref_req,
  input logic ref_active,
  input logic ras_n,
  input logic cas_n,
  input logic init_done,
  input logic deadline_miss
);
  assert_cas_leads_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  assert_strobes_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> ref_active);

  assert_start_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_active) |-> $past(ref_req && ref_gnt));

  assert_no_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_active |-> !ref_req);

  assert_miss_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deadline_miss |=> deadline_miss);

  assert_miss_drops_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadline_miss) |-> !init_done);
endmodule

bind dram_refresh_seq dref_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .ref_active(ref_active), .ras_n(ras_n), .cas_n(cas_n),
  .init_done(init_done), .deadline_miss(deadline_miss)
);

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
  localparam int P_PAUSE = 200;
  localparam int P_WAKE  = 8;
  localparam int P_IVL   = 100;
  localparam int P_BMAX  = 4;

  // {ras_n, cas_n, ref_active} per cycle of one refresh (CSR 1, RAS 8, CHR 2, PRE 5)
  localparam logic [2:0] STROBE_TBL [0:13] = '{
    3'b101, 3'b001, 3'b001, 3'b011, 3'b011, 3'b011, 3'b011,
    3'b011, 3'b011, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111
  };

  logic clk = 1'b0;
  logic rst_n, ref_gnt;
  logic ref_req, ref_active, ras_n, cas_n, init_done, deadline_miss;

  int checks = 0;
  int fails = 0;
  int ras_falls = 0;
  int lead_err = 0;
  int base;
  logic prev_ras = 1'b1;
  logic prev_cas = 1'b1;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(P_PAUSE), .WAKE_COUNT(P_WAKE),
    .INTERVAL_CYC(P_IVL), .BACKLOG_MAX(P_BMAX)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_active(ref_active), .ras_n(ras_n), .cas_n(cas_n),
    .init_done(init_done), .deadline_miss(deadline_miss)
  );

  always @(negedge clk) begin
    if (prev_ras && !ras_n) begin
      ras_falls++;
      if (prev_cas) lead_err++;
    end
    prev_ras <= ras_n;
    prev_cas <= cas_n;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_init(input logic val);
    do @(negedge clk); while (init_done !== val);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ras_n", int'(ras_n), 1);
    chk("R1 cas_n", int'(cas_n), 1);
    chk("R1 req", int'(ref_req), 0);
    chk("R1 active", int'(ref_active), 0);
    chk("R1 init", int'(init_done), 0);
    chk("R1 miss", int'(deadline_miss), 0);
    ref_gnt = 1'b1;
    rst_n   = 1'b1;

    repeat (P_PAUSE - 1) @(negedge clk);
    chk("R2 req before pause end", int'(ref_req), 0);
    chk("R1 strobes idle in pause", int'({ras_n, cas_n}), 3);
    @(negedge clk);
    chk("R2 req at pause end", int'(ref_req), 1);

    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      chk($sformatf("R5 step %0d", i), int'({ras_n, cas_n, ref_active}), int'(STROBE_TBL[i]));
    end
    @(negedge clk);
    chk("R5 idle after cycle", int'(ref_active), 0);
    chk("R9 req back after cycle", int'(ref_req), 1);

    ref_gnt = 1'b0;
    repeat (20) @(negedge clk);
    chk("R4 ras held high", int'(ras_n), 1);
    chk("R4 not active", int'(ref_active), 0);
    chk("R4 req held", int'(ref_req), 1);

    ref_gnt = 1'b1;
    wait_init(1'b1);
    ref_gnt = 1'b0;
    chk("R3 wake cycles", ras_falls, P_WAKE);

    repeat (P_IVL - 1) @(negedge clk);
    chk("R6 req before interval", int'(ref_req), 0);
    @(negedge clk);
    chk("R6 req at interval", int'(ref_req), 1);

    repeat (2 * P_IVL + 10) @(negedge clk);
    base = ras_falls;
    ref_gnt = 1'b1;
    repeat (60) @(negedge clk);
    ref_gnt = 1'b0;
    chk("R7 owed cycles paid", ras_falls - base, 3);
    chk("R7 req low when paid", int'(ref_req), 0);

    do @(negedge clk); while (!ref_req);
    repeat (3 * P_IVL + 10) @(negedge clk);
    chk("R8 no miss at full backlog", int'(deadline_miss), 0);
    chk("R8 init kept at full backlog", int'(init_done), 1);
    repeat (P_IVL) @(negedge clk);
    chk("R8 miss set", int'(deadline_miss), 1);
    chk("R8 init dropped", int'(init_done), 0);
    chk("R8 wake requested", int'(ref_req), 1);

    base = ras_falls;
    ref_gnt = 1'b1;
    wait_init(1'b1);
    ref_gnt = 1'b0;
    chk("R8 rerun burst", ras_falls - base, P_WAKE);
    chk("R8 miss sticky", int'(deadline_miss), 1);
    chk("R5 cas lead errors", lead_err, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule